// File: doc/BRIEF.md
# Bus Slave with Held Termination

This block is a bus slave for the common open on-chip bus, classic single-transfer cycles only. It sits in front of a small word-addressed register array. A master opens a transfer by raising its cycle and strobe lines with an address, and raises write-enable for a write. The slave waits a fixed number of clocks, set by a parameter, before it answers. It then ends the transfer with one of three responses: acknowledge for a normal transfer, error for an address outside the array, or retry for a write that enables no byte lane.

The response is a level, not a one-clock pulse. Once raised, it stays high as long as the master keeps both cycle and strobe high, so a master that samples a clock late still sees it. The response is gated by cycle and strobe, so it falls in the same clock that the master withdraws either line. The slave only arms again after it has sampled the strobe low at a clock edge. A following transfer therefore waits out the full latency and never inherits a response left over from the one before.

Top module: `wbh_slave`

## Requirements
- R1: A synchronous reset clears the wait counter, the three response outputs, the read data output and every word of the array to zero.
- R2: The first rising edge at which cycle and strobe are both sampled high counts as edge 1. The response becomes visible right after edge WAIT_CYCLES+1 and never earlier. WAIT_CYCLES may be set from 1 to 15.
- R3: At most one of busAck, busErr and busRty is high at any time.
- R4: Once raised, the response stays high for as long as busCyc and busStb both stay high.
- R5: All three responses are low in any cycle where busCyc or busStb is low. This includes the same cycle in which the master drops either line.
- R6: After a transfer ends, a new strobe is answered only after the full latency of R2 from its own first sampled edge.
- R7: A word address (busAddr) at or above NUM_WORDS ends the transfer with busErr. Such a write changes no word, and such a read returns zero data.
- R8: A write whose busSel is all zeros ends with busRty and changes no word.
- R9: During an acknowledged read, busRdata holds the addressed word for as long as busAck stays high. At all other times busRdata is zero.
- R10: An acknowledged write updates only the byte lanes enabled in busSel, where bit i enables data bits 8i+7..8i. It takes effect once, at the edge that raises busAck.
- R11: If the master drops the strobe before the latency ends, the transfer is abandoned. No response appears and no word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busCyc | input | 1 | Master holds a cycle open |
| busStb | input | 1 | Master requests a transfer |
| busWe | input | 1 | High for write, low for read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| busSel | input | DATA_W/8 | Byte-lane enables |
| busRdata | output | DATA_W | Read data, valid while busAck is held on a read |
| busAck | output | 1 | Normal termination, held |
| busErr | output | 1 | Error termination, held |
| busRty | output | 1 | Retry termination, held |

## Verification
The bench probes two failure modes. A slave that pulses its response for a single clock is caught by the master holding the strobe several clocks past the response. A slave that re-arms too early is caught by back-to-back transfers separated by a single idle edge, which would show up as a response in the first clock of the new strobe. Addresses just past the array, and addresses whose low bits alias a real word, expose a range check that only looks at the index bits: such a slave would corrupt the aliased word. A partial-lane write, an all-zero-lane write and a strobe dropped mid-wait check that only the intended bytes change, and only once.

// File: rtl/wbh_pkg.sv
package wbh_pkg;

  typedef enum logic [1:0] {
    TERM_NONE,
    TERM_ACK,
    TERM_ERR,
    TERM_RTY
  } termKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdCap;
  } dpStrobe_t;

endpackage

// File: rtl/wbh_ctrl.sv
module wbh_ctrl
  import wbh_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SEL_W       = 4,
  parameter int NUM_WORDS   = 12,
  parameter int WAIT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SEL_W-1:0]  busSel,
  output dpStrobe_t         dpStrobe,
  output logic              termRead,
  output logic              busAck,
  output logic              busErr,
  output logic              busRty
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

  generate
    if (WAIT_CYCLES < 1 || WAIT_CYCLES > 15) begin : g_badWait
      $error("WAIT_CYCLES must lie in 1..15");
    end
  endgenerate

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_TERM} ctrlState_e;

  ctrlState_e       state;
  logic [CNT_W-1:0] waitCnt;
  termKind_e        termKind;
  termKind_e        nextKind;
  logic             req;
  logic             inRange;
  logic             finish;

  always_comb begin
    req     = busCyc & busStb;
    inRange = ({1'b0, busAddr} < (ADDR_W + 1)'(NUM_WORDS));
    if (!inRange)                    nextKind = TERM_ERR;
    else if (busWe && busSel == '0)  nextKind = TERM_RTY;
    else                             nextKind = TERM_ACK;
    finish         = (state == ST_WAIT) && req && (waitCnt == '0);
    dpStrobe.wrEn  = finish && (nextKind == TERM_ACK) && busWe;
    dpStrobe.rdCap = finish && (nextKind == TERM_ACK) && !busWe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      termKind <= TERM_NONE;
      termRead <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            state   <= ST_WAIT;
            waitCnt <= CNT_W'(WAIT_CYCLES - 1);
          end
        end
        ST_WAIT: begin
          if (!req) begin
            state <= ST_IDLE;
          end else if (waitCnt == '0) begin
            state    <= ST_TERM;
            termKind <= nextKind;
            termRead <= !busWe && (nextKind == TERM_ACK);
          end else begin
            waitCnt <= waitCnt - CNT_W'(1);
          end
        end
        ST_TERM: begin
          if (!req) begin
            state    <= ST_IDLE;
            termKind <= TERM_NONE;
            termRead <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // responses are levels gated by the live request
  assign busAck = req && (termKind == TERM_ACK);
  assign busErr = req && (termKind == TERM_ERR);
  assign busRty = req && (termKind == TERM_RTY);

  // run length of consecutively sampled request edges, for latency check
  logic [4:0] reqRun;
  logic       anyTerm;
  assign anyTerm = busAck | busErr | busRty;

  always_ff @(posedge clk) begin
    if (rst || !req)       reqRun <= '0;
    else if (reqRun != '1) reqRun <= reqRun + 5'd1;
  end

  a_r3_single_term: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busAck, busErr, busRty}));

  a_r4_term_held: assert property (@(posedge clk) disable iff (rst)
    (anyTerm && busCyc && busStb) |=> (anyTerm || !(busCyc && busStb)));

  a_r5_low_without_cycle: assert property (@(posedge clk) disable iff (rst)
    !busCyc |-> !anyTerm);

  a_r6_no_stale_term: assert property (@(posedge clk) disable iff (rst)
    (req && !$past(req)) |-> !anyTerm);

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(anyTerm) |-> (reqRun == 5'(WAIT_CYCLES + 1)));

endmodule

// File: rtl/wbh_regfile.sv
module wbh_regfile
  import wbh_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 4,
  parameter int NUM_WORDS = 12,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         dpStrobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [SEL_W-1:0]  busSel,
  input  logic              showData,
  output logic [DATA_W-1:0] busRdata
);

  localparam int BYTE_W = DATA_W / SEL_W;

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] rdReg;

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      for (genvar b = 0; b < SEL_W; b++) begin : g_lane
        always_ff @(posedge clk) begin
          if (rst) begin
            mem[w][b*BYTE_W +: BYTE_W] <= '0;
          end else if (dpStrobe.wrEn && wordIdx == IDX_W'(w) && busSel[b]) begin
            mem[w][b*BYTE_W +: BYTE_W] <= busWdata[b*BYTE_W +: BYTE_W];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (wordIdx == IDX_W'(i)) rdMux = mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 rdReg <= '0;
    else if (dpStrobe.rdCap) rdReg <= rdMux;
  end

  assign busRdata = showData ? rdReg : '0;

  a_r10_write_once: assert property (@(posedge clk) disable iff (rst)
    dpStrobe.wrEn |=> !dpStrobe.wrEn);

  a_r9_data_stable: assert property (@(posedge clk) disable iff (rst)
    (showData && $past(showData)) |-> $stable(busRdata));

endmodule

// File: rtl/wbh_slave.sv
module wbh_slave
  import wbh_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_WORDS   = 12,
  parameter int WAIT_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busCyc,
  input  logic                  busStb,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [DATA_W/8-1:0]   busSel,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  busAck,
  output logic                  busErr,
  output logic                  busRty
);

  localparam int SEL_W = DATA_W / 8;
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  dpStrobe_t dpStrobe;
  logic      termRead;

  wbh_ctrl #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NUM_WORDS(NUM_WORDS), .WAIT_CYCLES(WAIT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .busSel(busSel), .dpStrobe(dpStrobe), .termRead(termRead),
    .busAck(busAck), .busErr(busErr), .busRty(busRty)
  );

  wbh_regfile #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) u_regfile (
    .clk(clk), .rst(rst), .dpStrobe(dpStrobe), .wordIdx(busAddr[IDX_W-1:0]),
    .busWdata(busWdata), .busSel(busSel), .showData(busAck && termRead),
    .busRdata(busRdata)
  );

endmodule

// File: tb/wbh_slave_tb.sv
module wbh_slave_tb;

  localparam int W  = 3;
  localparam int NW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  sel = '0;
  logic [31:0] rdata;
  logic        ack, err, rty;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wbh_slave #(.ADDR_W(8), .DATA_W(32), .NUM_WORDS(NW), .WAIT_CYCLES(W)) u_dut (
    .clk(clk), .rst(rst), .busCyc(cyc), .busStb(stb), .busWe(we), .busAddr(addr),
    .busWdata(wdata), .busSel(sel), .busRdata(rdata), .busAck(ack), .busErr(err),
    .busRty(rty)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: count of consecutive sampled request edges
  int          phase = 0;
  int          refKind = 0;   // 0 none, 1 ack, 2 err, 3 rty
  bit          refRead = 0;
  logic [31:0] refRd = '0;
  logic [31:0] refMem [NW];
  bit          modelOn = 0;

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; refKind = 0; refRead = 0; refRd = '0;
      foreach (refMem[i]) refMem[i] = '0;
    end else if (!(cyc && stb)) begin
      phase = 0; refKind = 0; refRead = 0;
    end else if (phase < W) begin
      phase++;
    end else if (phase == W) begin
      phase = W + 1;
      if (int'(addr) >= NW)            refKind = 2;
      else if (we && sel == 4'b0)      refKind = 3;
      else begin
        refKind = 1;
        if (we) begin
          for (int b = 0; b < 4; b++)
            if (sel[b]) refMem[addr][8*b +: 8] = wdata[8*b +: 8];
        end else begin
          refRead = 1;
          refRd = refMem[addr];
        end
      end
    end
    #3;
    if (modelOn) begin
      logic [2:0]  expT;
      logic [31:0] expD;
      expT = {cyc && stb && refKind == 1, cyc && stb && refKind == 2,
              cyc && stb && refKind == 3};
      expD = (expT[2] && refRead) ? refRd : 32'h0;
      check({ack, err, rty} == expT, "R2 R3 R4 R5 per-cycle term",
            {29'b0, ack, err, rty}, {29'b0, expT});
      check(rdata == expD, "R9 per-cycle data", rdata, expD);
    end
  end

  task automatic xfer(input bit w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, input int extra, output int lat,
                      output logic [2:0] term, output logic [31:0] rd);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; addr = a; wdata = d; sel = s;
    lat = 0; term = '0;
    while (term == '0 && lat < 40) begin
      @(posedge clk); #3; lat++;
      term = {ack, err, rty};
    end
    rd = rdata;
    for (int i = 0; i < extra; i++) begin
      @(posedge clk); #3;
      check({ack, err, rty} == term, "R4 held response", {29'b0, ack, err, rty},
            {29'b0, term});
      check(rdata == rd, "R9 held data", rdata, rd);
    end
    @(negedge clk);
    stb = 0; cyc = 0;
    #1;
    check({ack, err, rty} == 3'b0, "R5 drop on strobe low", {29'b0, ack, err, rty}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [2:0]  t;
    logic [31:0] d;

    repeat (3) @(posedge clk);
    #3;
    check({ack, err, rty} == 3'b0, "R1 reset responses", {29'b0, ack, err, rty}, 0);
    check(rdata == 0, "R1 reset data", rdata, 0);
    @(negedge clk); rst = 0;
    modelOn = 1;

    xfer(0, 8'd5, 0, 4'hF, 0, lat, t, d);
    check(d == 0, "R1 array cleared", d, 0);

    xfer(1, 8'd3, 32'hA5A5_1234, 4'hF, 2, lat, t, d);
    check(lat == W + 1, "R2 write latency", lat, W + 1);
    check(t == 3'b100, "R3 write acked", {29'b0, t}, 32'h4);

    xfer(0, 8'd3, 0, 4'hF, 3, lat, t, d);
    check(lat == W + 1, "R6 back-to-back latency", lat, W + 1);
    check(d == 32'hA5A5_1234, "R9 read data", d, 32'hA5A5_1234);

    xfer(1, 8'd3, 32'hFFFF_FFFF, 4'b0101, 0, lat, t, d);
    xfer(0, 8'd3, 0, 4'hF, 0, lat, t, d);
    check(d == 32'hA5FF_12FF, "R10 byte lanes", d, 32'hA5FF_12FF);

    xfer(1, 8'd3, 32'h0, 4'b0000, 1, lat, t, d);
    check(t == 3'b001, "R8 retry", {29'b0, t}, 1);
    xfer(0, 8'd3, 0, 4'hF, 0, lat, t, d);
    check(d == 32'hA5FF_12FF, "R8 no change", d, 32'hA5FF_12FF);

    xfer(1, 8'd12, 32'h1111_1111, 4'hF, 1, lat, t, d);
    check(t == 3'b010, "R7 error at limit", {29'b0, t}, 2);
    xfer(1, 8'd19, 32'h2222_2222, 4'hF, 0, lat, t, d);
    check(t == 3'b010, "R7 error aliased", {29'b0, t}, 2);
    xfer(0, 8'd200, 0, 4'hF, 0, lat, t, d);
    check(t == 3'b010 && d == 0, "R7 read error data", d, 0);
    xfer(0, 8'd3, 0, 4'hF, 0, lat, t, d);
    check(d == 32'hA5FF_12FF, "R7 alias untouched", d, 32'hA5FF_12FF);

    // R11: abandon a write before the latency ends
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; addr = 8'd7; wdata = 32'hDEAD_BEEF; sel = 4'hF;
    repeat (W) begin
      @(posedge clk); #3;
      check({ack, err, rty} == 3'b0, "R11 no response", {29'b0, ack, err, rty}, 0);
    end
    @(negedge clk); stb = 0;
    repeat (2) @(negedge clk);
    cyc = 0;
    xfer(0, 8'd7, 0, 4'hF, 0, lat, t, d);
    check(d == 0, "R11 no write", d, 0);

    // R5: strobe without cycle is never answered
    @(negedge clk);
    cyc = 0; stb = 1; we = 0; addr = 8'd3;
    repeat (W + 4) begin
      @(posedge clk); #3;
      check({ack, err, rty} == 3'b0, "R5 no cycle", {29'b0, ack, err, rty}, 0);
    end
    @(negedge clk); stb = 0;

    // R5: keep cycle, drop strobe while acked
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; addr = 8'd3;
    repeat (W + 2) @(posedge clk);
    #3;
    check(ack == 1'b1, "R4 ack up", {31'b0, ack}, 1);
    @(negedge clk); stb = 0; #1;
    check(ack == 1'b0, "R5 ack falls with strobe", {31'b0, ack}, 0);
    @(negedge clk); stb = 1; #1;
    check(ack == 1'b0, "R6 re-armed no stale ack", {31'b0, ack}, 0);
    @(negedge clk); cyc = 0; stb = 0;

    xfer(1, 8'd11, 32'h0BAD_F00D, 4'hF, 5, lat, t, d);
    xfer(0, 8'd11, 0, 4'hF, 0, lat, t, d);
    check(d == 32'h0BAD_F00D, "R10 last word", d, 32'h0BAD_F00D);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule